// File: doc/BRIEF.md
# Complement-Reduction Unsigned Divider

This block divides a 2N-bit unsigned dividend by an N-bit unsigned divisor over several clock cycles. It returns a 2N-bit quotient and an N-bit remainder. The loop never subtracts the divisor repeatedly. Instead it takes the complement of the divisor with respect to 2^N. On each step it splits the working value into an upper and a lower N-bit half, multiplies the upper half by that complement and adds the lower half back in. The upper halves taken off along the way are summed into the quotient. The loop ends once the working value is smaller than the divisor.

The divisor is first shifted left until its top bit is set. This keeps the complement at or below 2^(N-1), so each step at least halves the upper half and the number of cycles stays bounded. Once the reduction is done, the block undoes the shift with one compare-and-subtract step for each shifted position. Each of these steps appends one quotient bit. A zero divisor is answered at once with a flag. A step counter stops the loop with an error flag if it ever runs past its limit.

Use: hold `start` high for one cycle while `busy` is low, with the operands valid in that cycle. Then wait for the one-cycle `done` pulse.

Top module: `compl_div`

## Requirements
- R1: After reset, `busy`, `done`, `div_zero` and `cap_err` are 0, and `quotient` and `remainder` are 0.
- R2: For a nonzero divisor B and dividend D, `quotient` equals floor(D/B) and `remainder` equals D mod B in the cycle where `done` is 1.
- R3: In every `done` cycle of a nonzero division, `remainder` is strictly less than the divisor that was sampled at start.
- R4: `done` is high for exactly one cycle per accepted operation, and `busy` is low in that cycle.
- R5: A start with a divisor of 0 raises `done` after the very next clock edge, with `div_zero` = 1, `quotient` all ones, `remainder` 0, and `busy` staying low.
- R6: A `start` pulse seen while `busy` is 1 has no effect: the running operation finishes with the results of its own operands.
- R7: A nonzero division raises `done` no later than the (2N+4)th rising edge, counting the edge that accepts `start` as the first, and `cap_err` stays 0. While the upper half is nonzero, every reduction step makes the working value strictly smaller.
- R8: `quotient` and `remainder` change only in the cycle where `done` is 1, and they hold their values until the next operation completes.
- R9: A nonzero division that follows a divide-by-zero clears `div_zero` to 0 in its `done` cycle.
- R10: The extreme divisors 1 and 2^N-1 give exact results for any dividend, including the all-ones dividend and a dividend of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Operation request, sampled only while idle |
| dividend | input | 2N | Unsigned dividend |
| divisor | input | N | Unsigned divisor |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse: results are valid |
| quotient | output | 2N | Quotient (all ones on divide by zero) |
| remainder | output | N | Remainder (0 on divide by zero) |
| div_zero | output | 1 | Last operation had a zero divisor |
| cap_err | output | 1 | Last operation hit the step limit |

## Verification
A wrong quotient accumulation or a bad working-value update breaks the identity dividend = quotient × current divisor + working value. The bound checker tests this identity on every busy cycle, so the fault is caught within the same cycle it occurs, well before `done`. At the ports, the same fault appears only when `done` rises, as a quotient or remainder that differs from the bench's own floor division, or as a remainder not below the divisor. A reduction step that fails to shrink the working value shows up instead as a late `done` or a raised `cap_err`, at most 2N+4 cycles after start. The directed extremes (divisor 1 forcing the largest shift, divisor 2^N-1 needing no shift) exercise the reduction loop and the restoring loop on their own.

// File: rtl/ctd_pkg.sv
package ctd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_REDUCE = 2'd1,
    ST_SCALE  = 2'd2
  } ctd_state_e;
endpackage

// File: rtl/ctd_prescale.sv
// Left-aligns the divisor and forms its complement with respect to 2^N.
module ctd_prescale #(
  parameter int N = 27,
  localparam int SW = $clog2(N)
) (
  input  logic [N-1:0]  div_in,
  output logic [SW-1:0] shift,
  output logic [N-1:0]  norm_div,
  output logic [N-1:0]  comp
);
  function automatic logic [SW-1:0] lead_zeros(input logic [N-1:0] v);
    logic [SW-1:0] n;
    n = '0;
    for (int i = 0; i < N; i++) begin
      if (v[i]) n = SW'(N - 1 - i);
    end
    return n;
  endfunction

  function automatic logic [N-1:0] base_complement(input logic [N-1:0] v);
    return N'(0) - v;
  endfunction

  always_comb begin
    shift    = lead_zeros(div_in);
    norm_div = div_in << shift;
    comp     = base_complement(norm_div);
  end
endmodule

// File: rtl/ctd_reduce.sv
// One reduction step: next = upper * complement + lower.
module ctd_reduce #(
  parameter int N = 27,
  localparam int W2 = 2 * N
) (
  input  logic [W2-1:0] work,
  input  logic [N-1:0]  comp,
  output logic [N-1:0]  upper,
  output logic [W2-1:0] work_next
);
  function automatic logic [W2-1:0] fold(input logic [N-1:0] hi,
                                         input logic [N-1:0] lo,
                                         input logic [N-1:0] c);
    return W2'(hi) * W2'(c) + W2'(lo);
  endfunction

  always_comb begin
    upper     = work[W2-1:N];
    work_next = fold(work[W2-1:N], work[N-1:0], comp);
  end
endmodule

// File: rtl/ctd_restore.sv
// One de-scaling step: halve the divisor, subtract it if it fits.
module ctd_restore #(
  parameter int N = 27,
  localparam int W2 = 2 * N
) (
  input  logic [W2-1:0] work,
  input  logic [N-1:0]  dv,
  output logic [N-1:0]  dv_half,
  output logic          take,
  output logic [W2-1:0] work_next
);
  always_comb begin
    dv_half   = dv >> 1;
    take      = work >= W2'(dv_half);
    work_next = take ? work - W2'(dv_half) : work;
  end
endmodule

// File: rtl/compl_div.sv
module compl_div
  import ctd_pkg::*;
#(
  parameter int N = 27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [2*N-1:0]   dividend,
  input  logic [N-1:0]     divisor,
  output logic             busy,
  output logic             done,
  output logic [2*N-1:0]   quotient,
  output logic [N-1:0]     remainder,
  output logic             div_zero,
  output logic             cap_err
);
  localparam int W2  = 2 * N;
  localparam int SW  = $clog2(N);
  localparam int CAP = 3 * N;
  localparam int CW  = $clog2(CAP + 1);

  ctd_state_e    state;
  logic [W2-1:0] work, quot;
  logic [N-1:0]  dvr, comp_r;
  logic [SW-1:0] shift_r;
  logic [CW-1:0] cnt;

  logic [SW-1:0] pre_shift;
  logic [N-1:0]  pre_norm, pre_comp;
  logic [N-1:0]  red_hi;
  logic [W2-1:0] red_next;
  logic [N-1:0]  rs_half;
  logic          rs_take;
  logic [W2-1:0] rs_next;

  // named internal events
  logic accept, in_reduce, in_scale, hi_zero, below, cap_hit, last_scale;

  ctd_prescale #(.N(N)) u_pre (
    .div_in(divisor), .shift(pre_shift), .norm_div(pre_norm), .comp(pre_comp)
  );
  ctd_reduce #(.N(N)) u_red (
    .work(work), .comp(comp_r), .upper(red_hi), .work_next(red_next)
  );
  ctd_restore #(.N(N)) u_rst (
    .work(work), .dv(dvr), .dv_half(rs_half), .take(rs_take), .work_next(rs_next)
  );

  always_comb begin
    accept     = start && (state == ST_IDLE);
    in_reduce  = (state == ST_REDUCE);
    in_scale   = (state == ST_SCALE);
    hi_zero    = (red_hi == '0);
    below      = work < W2'(dvr);
    cap_hit    = (cnt == CW'(CAP - 1));
    last_scale = (shift_r == SW'(1));
    busy       = (state != ST_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      work      <= '0;
      quot      <= '0;
      dvr       <= '0;
      comp_r    <= '0;
      shift_r   <= '0;
      cnt       <= '0;
      done      <= 1'b0;
      quotient  <= '0;
      remainder <= '0;
      div_zero  <= 1'b0;
      cap_err   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            cap_err <= 1'b0;
            if (divisor == '0) begin
              done      <= 1'b1;
              div_zero  <= 1'b1;
              quotient  <= '1;
              remainder <= '0;
            end else begin
              div_zero <= 1'b0;
              work     <= dividend;
              quot     <= '0;
              dvr      <= pre_norm;
              comp_r   <= pre_comp;
              shift_r  <= pre_shift;
              cnt      <= '0;
              state    <= ST_REDUCE;
            end
          end
        end
        ST_REDUCE: begin
          cnt <= cnt + 1'b1;
          if (cap_hit) begin
            state     <= ST_IDLE;
            done      <= 1'b1;
            cap_err   <= 1'b1;
            quotient  <= quot;
            remainder <= work[N-1:0];
          end else if (!hi_zero) begin
            work <= red_next;
            quot <= quot + W2'(red_hi);
          end else if (!below) begin
            work <= work - W2'(dvr);
            quot <= quot + 1'b1;
          end else if (shift_r == '0) begin
            state     <= ST_IDLE;
            done      <= 1'b1;
            quotient  <= quot;
            remainder <= work[N-1:0];
          end else begin
            state <= ST_SCALE;
          end
        end
        ST_SCALE: begin
          cnt <= cnt + 1'b1;
          if (cap_hit) begin
            state     <= ST_IDLE;
            done      <= 1'b1;
            cap_err   <= 1'b1;
            quotient  <= quot;
            remainder <= work[N-1:0];
          end else begin
            work    <= rs_next;
            quot    <= {quot[W2-2:0], rs_take};
            dvr     <= rs_half;
            shift_r <= shift_r - 1'b1;
            if (last_scale) begin
              state     <= ST_IDLE;
              done      <= 1'b1;
              quotient  <= {quot[W2-2:0], rs_take};
              remainder <= rs_next[N-1:0];
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ctd_checker.sv
module ctd_checker #(
  parameter int N = 27,
  localparam int W2 = 2 * N,
  localparam int W3 = 3 * N
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [W2-1:0] dividend,
  input logic [N-1:0]  divisor,
  input logic          busy,
  input logic          done,
  input logic [W2-1:0] quotient,
  input logic [N-1:0]  remainder,
  input logic          div_zero,
  input logic          cap_err,
  input logic          in_reduce,
  input logic          hi_zero,
  input logic [W2-1:0] work,
  input logic [W2-1:0] quot,
  input logic [N-1:0]  dvr
);
  logic [W2-1:0] seen_d;
  logic [N-1:0]  seen_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_d <= '0;
      seen_b <= '0;
    end else if (start && !busy && divisor != '0) begin
      seen_d <= dividend;
      seen_b <= divisor;
    end
  end

  logic [W3-1:0] recomposed;
  always_comb recomposed = W3'(quot) * W3'(dvr) + W3'(work);

  AST_KEEP_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (recomposed == W3'(seen_d))); // R2
  AST_REM_BELOW_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_zero) |-> (remainder < seen_b)); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R4
  AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R4
  AST_ZERO_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && divisor == '0) |=>
      (done && div_zero && !busy && quotient == '1 && remainder == '0)); // R5
  AST_STEP_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_reduce && !hi_zero) |=> (work < $past(work))); // R7
  AST_NO_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_err); // R7
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(quotient) && $stable(remainder))); // R8
endmodule

bind compl_div ctd_checker #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
  .divisor(divisor), .busy(busy), .done(done), .quotient(quotient),
  .remainder(remainder), .div_zero(div_zero), .cap_err(cap_err),
  .in_reduce(in_reduce), .hi_zero(hi_zero), .work(work), .quot(quot),
  .dvr(dvr)
);

// File: tb/sim_compl_div.sv
`timescale 1ns/1ps
module sim_compl_div;
  localparam int N  = 27;
  localparam int W2 = 2 * N;
  localparam int LAT_MAX = 2 * N + 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [W2-1:0] dividend = '0;
  logic [N-1:0]  divisor = '0;
  logic          busy, done, div_zero, cap_err;
  logic [W2-1:0] quotient;
  logic [N-1:0]  remainder;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  compl_div #(.N(N)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
    .divisor(divisor), .busy(busy), .done(done), .quotient(quotient),
    .remainder(remainder), .div_zero(div_zero), .cap_err(cap_err)
  );

  task automatic check(input bit ok, input string req, input longint unsigned act,
                       input longint unsigned exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic longint unsigned ref_q(input longint unsigned d, input longint unsigned b);
    return d / b;
  endfunction
  function automatic longint unsigned ref_r(input longint unsigned d, input longint unsigned b);
    return d - (d / b) * b;
  endfunction

  // start at a negedge, count edges from the accepting edge until done
  task automatic run_div(input logic [W2-1:0] d, input logic [N-1:0] b, input string tag);
    int lat;
    longint unsigned dq, dr, bb;
    @(negedge clk);
    dividend = d; divisor = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 4 * N) begin
      @(negedge clk);
      lat++;
    end
    dq = longint'(d); bb = longint'(b);
    check(done === 1'b1, {"R7 done seen ", tag}, longint'(done), 1);
    check(lat <= LAT_MAX, {"R7 latency ", tag}, lat, LAT_MAX);
    check(cap_err === 1'b0, {"R7 cap_err ", tag}, longint'(cap_err), 0);
    check(busy === 1'b0, {"R4 busy at done ", tag}, longint'(busy), 0);
    check(quotient == ref_q(dq, bb), {"R2 quotient ", tag}, quotient, ref_q(dq, bb));
    dr = ref_r(dq, bb);
    check(remainder == dr, {"R2 remainder ", tag}, remainder, dr);
    check(remainder < b, {"R3 rem<div ", tag}, remainder, bb);
    check(div_zero === 1'b0, {"R9 div_zero low ", tag}, longint'(div_zero), 0);
    @(negedge clk);
    check(done === 1'b0, {"R4 done one cycle ", tag}, longint'(done), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [W2-1:0] d, hq;
    logic [N-1:0]  b, hr;
    int sel;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy === 1'b0 && done === 1'b0, "R1 busy/done", {busy, done}, 0);
    check(quotient === '0 && remainder === '0, "R1 results", quotient, 0);
    check(div_zero === 1'b0 && cap_err === 1'b0, "R1 flags", {div_zero, cap_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 extremes
    run_div('1, N'(1), "R10 max/1");
    run_div('1, '1, "R10 max/allones");
    run_div('0, N'(1), "R10 zero/1");
    run_div('0, '1, "R10 zero/allones");
    run_div(W2'(5), N'(9), "R2 d<b");
    run_div(W2'(N'(3)) * W2'(1000), N'(3), "R2 exact");
    run_div('1, N'(1) << (N - 1), "R2 pow2 top");
    run_div(W2'(12345), N'(12345), "R2 d==b");

    // R5 divide by zero
    @(negedge clk);
    dividend = W2'(77); divisor = '0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done === 1'b1, "R5 done next cycle", longint'(done), 1);
    check(div_zero === 1'b1, "R5 flag", longint'(div_zero), 1);
    check(quotient === '1, "R5 quotient ones", quotient, longint'({W2{1'b1}}));
    check(remainder === '0, "R5 remainder zero", remainder, 0);
    check(busy === 1'b0, "R5 busy low", longint'(busy), 0);
    // R9 next nonzero op clears flag (checked inside run_div)
    run_div(W2'(1000), N'(7), "R9 after dz");

    // R6 start during busy ignored
    @(negedge clk);
    dividend = W2'(64'h3_FFFF_0000_1234); divisor = N'(3); start = 1'b1;
    @(negedge clk);
    dividend = W2'(99); divisor = N'(5);  // start still high while busy
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    check(quotient == ref_q(64'h3_FFFF_0000_1234, 3), "R6 quotient",
          quotient, ref_q(64'h3_FFFF_0000_1234, 3));
    check(remainder == ref_r(64'h3_FFFF_0000_1234, 3), "R6 remainder",
          remainder, ref_r(64'h3_FFFF_0000_1234, 3));

    // R8 hold after done
    hq = quotient; hr = remainder;
    repeat (5) @(negedge clk);
    check(quotient == hq && remainder == hr, "R8 held", quotient, hq);

    // constrained random
    for (int i = 0; i < 60; i++) begin
      d = W2'({$urandom, $urandom});
      sel = int'($urandom % 4);
      case (sel)
        0: b = N'($urandom);
        1: b = N'($urandom % 256);
        2: b = '1 - N'($urandom % 256);
        default: b = N'(1) << ($urandom % N);
      endcase
      if (b == '0) b = N'(1);
      if (i % 5 == 0) d = d >> ($urandom % W2);
      run_div(d, b, "R2 random");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule